// File: doc/BRIEF.md
# Three-Wire Control Port Receiver

This block is a write-only slave on a three-wire serial control port. The port has a serial clock, a serial data line and a mode line. A host uses the port to program an audio codec's settings. All three lines are brought into the fast system clock domain through a synchroniser. The block detects rising edges of the serial clock there and shifts data in least significant bit first, one byte at a time.

A byte received with the mode line low is an address byte. Its upper six bits are compared with the device's own address, and its lower two bits choose a transfer type. The type stays in force until the next address byte arrives. A byte received with the mode line high is a data byte. While the device is selected and the type names a register group, the top two bits of the data byte pick one of four registers in that group. The lower six bits are written into that register. The register contents drive the codec's setting outputs directly.

Top module: `ctl3w_rx`

## Requirements
- R1: After reset every setting output is zero and the device is deselected, so data bytes received before any address byte write nothing.
- R2: Serial data is taken on each rising edge of the serial clock. The first bit of a byte is bit 0 and the eighth bit is bit 7.
- R3: A byte received with the mode line low is an address byte. The device is selected only when bits 7:2 equal 000101 (bit 7 the MSB). Bits 1:0 become the transfer type.
- R4: With transfer type 00, bits 7:6 of a data byte pick the data-group register and bits 5:0 are written to it. The registers are: 0 volume (`volLevel`), 1 bass (`bassLevel`), 2 treble (`trebleLevel`), 3 mute/mode/power flags (`miscCtrl`).
- R5: With transfer type 10, bits 7:6 of a data byte pick status register n and bits 5:0 are written to `statusCfg[6n+5:6n]`.
- R6: With transfer type 01 or 11, data bytes change no output.
- R7: An address byte whose bits 7:2 differ from 000101 deselects the device, and later data bytes change no output.
- R8: One address selection applies to any number of following data bytes.
- R9: A register changes only after the eighth bit of a byte. Any change of the mode line clears the bit count, so a partial byte is discarded.
- R10: Each completed data byte writes at most one register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rstN | input | 1 | Active-low reset |
| serClk | input | 1 | Serial clock; data is taken on its rising edge |
| serData | input | 1 | Serial data, LSB first |
| serMode | input | 1 | Low for an address byte, high for a data byte |
| volLevel | output | 6 | Data-group register 0 |
| bassLevel | output | 6 | Data-group register 1 |
| trebleLevel | output | 6 | Data-group register 2 |
| miscCtrl | output | 6 | Data-group register 3 (mute, mode, power flags) |
| statusCfg | output | 24 | Status-group registers 0..3, 6 bits each |

## Verification
The assertions assume clean serial traffic:
- each level of the serial clock lasts at least two system clocks;
- the data line is steady around each rising serial edge;
- the mode line moves only while the serial clock is low and never in the same cycle as a serial edge.

The stimulus keeps to these rules. It holds every serial clock phase for four system clocks and sets data during the low phase. After each mode change it waits several cycles before the first pulse. Partial bytes are produced only by stopping pulses and then toggling the mode line.

// File: rtl/ctl3w_pkg.sv
package ctl3w_pkg;
  typedef struct packed {
    logic shift;
    logic wrData;
    logic wrStat;
  } ctl3w_stb_t;

  localparam logic [1:0] XFER_DATA = 2'b00;
  localparam logic [1:0] XFER_STAT = 2'b10;
endpackage

// File: rtl/ctl3w_sync.sv
module ctl3w_sync #(
  parameter int W = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain[0] <= '0;
    else       chain[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain[s] <= '0;
      else       chain[s] <= chain[s-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/ctl3w_ctrl.sv
module ctl3w_ctrl
  import ctl3w_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 6,
  parameter logic [ADDR_W-1:0] DEV_ADDR = 6'b000101,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W = $clog2(BYTE_W),
  localparam int TYPE_W = BYTE_W - ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serClk,
  input  logic              serData,
  input  logic              serMode,
  input  logic [BYTE_W-1:0] nextByte,
  output ctl3w_stb_t        stb,
  output logic              dataBit,
  output logic              devSel,
  output logic [TYPE_W-1:0] xferType,
  output logic [CNT_W-1:0]  bitCnt,
  output logic              modeS
);
  logic clkS, clkPrev, modePrev;
  logic clkRise, modeChg, byteEnd;
  logic [2:0] syncOut;

  ctl3w_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  ({serClk, serData, serMode}),
    .dout (syncOut)
  );

  assign clkS    = syncOut[2];
  assign dataBit = syncOut[1];
  assign modeS   = syncOut[0];

  assign clkRise = clkS & ~clkPrev;
  assign modeChg = modeS ^ modePrev;

  always_comb begin
    stb        = '0;
    stb.shift  = clkRise & ~modeChg;
    byteEnd    = stb.shift && (bitCnt == CNT_W'(BYTE_W - 1));
    stb.wrData = byteEnd & modeS & devSel & (xferType == TYPE_W'(XFER_DATA));
    stb.wrStat = byteEnd & modeS & devSel & (xferType == TYPE_W'(XFER_STAT));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPrev  <= 1'b0;
      modePrev <= 1'b0;
      bitCnt   <= '0;
      devSel   <= 1'b0;
      xferType <= '0;
    end else begin
      clkPrev  <= clkS;
      modePrev <= modeS;
      if (modeChg)      bitCnt <= '0;
      else if (byteEnd) bitCnt <= '0;
      else if (stb.shift) bitCnt <= bitCnt + 1'b1;
      if (byteEnd && !modeS) begin
        devSel   <= (nextByte[BYTE_W-1 -: ADDR_W] == DEV_ADDR);
        xferType <= nextByte[TYPE_W-1:0];
      end
    end
  end
endmodule

// File: rtl/ctl3w_dp.sv
module ctl3w_dp
  import ctl3w_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int VAL_W = 6,
  parameter int REGS = 4,
  localparam int SEL_W = $clog2(REGS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctl3w_stb_t            stb,
  input  logic                  dataBit,
  output logic [BYTE_W-1:0]     nextByte,
  output logic [REGS*VAL_W-1:0] dataRegs,
  output logic [REGS*VAL_W-1:0] statRegs
);
  logic [BYTE_W-1:0] shiftReg;
  logic [SEL_W-1:0]  regSel;
  logic [VAL_W-1:0]  regVal;
  logic [VAL_W-1:0]  dataArr [REGS];
  logic [VAL_W-1:0]  statArr [REGS];

  assign nextByte = {dataBit, shiftReg[BYTE_W-1:1]};
  assign regSel   = nextByte[BYTE_W-1 -: SEL_W];
  assign regVal   = nextByte[VAL_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          shiftReg <= '0;
    else if (stb.shift) shiftReg <= nextByte;
  end

  for (genvar g = 0; g < REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dataArr[g] <= '0;
        statArr[g] <= '0;
      end else begin
        if (stb.wrData && regSel == SEL_W'(g)) dataArr[g] <= regVal;
        if (stb.wrStat && regSel == SEL_W'(g)) statArr[g] <= regVal;
      end
    end
    assign dataRegs[g*VAL_W +: VAL_W] = dataArr[g];
    assign statRegs[g*VAL_W +: VAL_W] = statArr[g];
  end
endmodule

// File: rtl/ctl3w_rx.sv
module ctl3w_rx
  import ctl3w_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 6,
  parameter logic [ADDR_W-1:0] DEV_ADDR = 6'b000101,
  parameter int SYNC_STAGES = 2,
  parameter int VAL_W = 6,
  parameter int REGS = 4,
  localparam int CNT_W = $clog2(BYTE_W),
  localparam int TYPE_W = BYTE_W - ADDR_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  serClk,
  input  logic                  serData,
  input  logic                  serMode,
  output logic [VAL_W-1:0]      volLevel,
  output logic [VAL_W-1:0]      bassLevel,
  output logic [VAL_W-1:0]      trebleLevel,
  output logic [VAL_W-1:0]      miscCtrl,
  output logic [REGS*VAL_W-1:0] statusCfg
);
  ctl3w_stb_t            stb;
  logic                  dataBit;
  logic                  devSel;
  logic [TYPE_W-1:0]     xferType;
  logic [CNT_W-1:0]      bitCnt;
  logic                  modeS;
  logic [BYTE_W-1:0]     nextByte;
  logic [REGS*VAL_W-1:0] dataRegs;
  logic [REGS*VAL_W-1:0] statRegs;

  ctl3w_ctrl #(
    .BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .DEV_ADDR(DEV_ADDR), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData), .serMode(serMode),
    .nextByte(nextByte), .stb(stb), .dataBit(dataBit), .devSel(devSel),
    .xferType(xferType), .bitCnt(bitCnt), .modeS(modeS)
  );

  ctl3w_dp #(.BYTE_W(BYTE_W), .VAL_W(VAL_W), .REGS(REGS)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .dataBit(dataBit),
    .nextByte(nextByte), .dataRegs(dataRegs), .statRegs(statRegs)
  );

  assign volLevel    = dataRegs[0*VAL_W +: VAL_W];
  assign bassLevel   = dataRegs[1*VAL_W +: VAL_W];
  assign trebleLevel = dataRegs[2*VAL_W +: VAL_W];
  assign miscCtrl    = dataRegs[3*VAL_W +: VAL_W];
  assign statusCfg   = statRegs;
endmodule

// File: rtl/ctl3w_chk.sv
module ctl3w_chk
  import ctl3w_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CNT_W = 3,
  parameter int BANK_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input ctl3w_stb_t        stb,
  input logic [CNT_W-1:0]  bitCnt,
  input logic              devSel,
  input logic              modeS,
  input logic [BANK_W-1:0] dataRegs,
  input logic [BANK_W-1:0] statRegs
);
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (dataRegs == '0 && statRegs == '0 && !devSel));

  p_write_at_byte_end_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrData || stb.wrStat) |-> (bitCnt == CNT_W'(BYTE_W - 1) && modeS));

  p_mode_clears_count_r9: assert property (@(posedge clk) disable iff (!rstN)
    (modeS != $past(modeS)) |=> (bitCnt == '0));

  p_one_write_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrData, stb.wrStat}));

  p_write_needs_sel_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrData || stb.wrStat) |-> devSel);

  p_data_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wrData |=> $stable(dataRegs));

  p_stat_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wrStat |=> $stable(statRegs));
endmodule

bind ctl3w_rx ctl3w_chk #(.BYTE_W(BYTE_W), .CNT_W(CNT_W), .BANK_W(REGS*VAL_W)) u_chk (
  .clk(clk), .rstN(rstN), .stb(stb), .bitCnt(bitCnt), .devSel(devSel),
  .modeS(modeS), .dataRegs(dataRegs), .statRegs(statRegs)
);

// File: tb/ctl3w_rx_bench.sv
module ctl3w_rx_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b0;
  logic serData = 1'b0;
  logic serMode = 1'b0;
  logic [5:0] volLevel, bassLevel, trebleLevel, miscCtrl;
  logic [23:0] statusCfg;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  typedef struct {
    string       tag;
    logic [5:0]  v, b, t, m;
    logic [23:0] s;
  } snap_t;

  snap_t q[$];
  snap_t cur;

  logic [5:0] expData [4];
  logic [5:0] expStat [4];
  bit         modelSel = 1'b0;
  logic [1:0] modelType = 2'b00;

  always #4 clk = ~clk;

  ctl3w_rx u_ctl3w_rx (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData), .serMode(serMode),
    .volLevel(volLevel), .bassLevel(bassLevel), .trebleLevel(trebleLevel),
    .miscCtrl(miscCtrl), .statusCfg(statusCfg)
  );

  task automatic waitClk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pushExp(input string tag);
    snap_t e;
    e.tag = tag;
    e.v = expData[0]; e.b = expData[1]; e.t = expData[2]; e.m = expData[3];
    e.s = {expStat[3], expStat[2], expStat[1], expStat[0]};
    q.push_back(e);
  endtask

  task automatic sendBits(input logic [7:0] val, input int n);
    for (int i = 0; i < n; i++) begin
      serData = val[i];
      waitClk(4);
      serClk = 1'b1;
      waitClk(4);
      serClk = 1'b0;
    end
  endtask

  // One whole byte plus the reference model update taken from the requirements
  task automatic sendByte(input logic mode, input logic [7:0] val, input string tag);
    serMode = mode;
    waitClk(6);
    sendBits(val, 8);
    waitClk(8);
    if (!mode) begin
      modelSel  = (val[7:2] == 6'b000101);
      modelType = val[1:0];
    end else if (modelSel) begin
      if (modelType == 2'b00)      expData[val[7:6]] = val[5:0];
      else if (modelType == 2'b10) expStat[val[7:6]] = val[5:0];
    end
    pushExp(tag);
  endtask

  // Monitor: pops expected snapshots and compares away from the active edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      cur = q.pop_front();
      total++;
      if (volLevel !== cur.v || bassLevel !== cur.b || trebleLevel !== cur.t ||
          miscCtrl !== cur.m || statusCfg !== cur.s) begin
        bad++;
        $display("FAIL %s: actual v=%h b=%h t=%h m=%h s=%h expected v=%h b=%h t=%h m=%h s=%h",
                 cur.tag, volLevel, bassLevel, trebleLevel, miscCtrl, statusCfg,
                 cur.v, cur.b, cur.t, cur.m, cur.s);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      expData[i] = '0;
      expStat[i] = '0;
    end
    waitClk(5);
    rstN = 1'b1;
    waitClk(3);
    pushExp("R1 reset state");
    waitClk(2);
    // R1: deselected at start, data byte ignored
    sendByte(1'b1, 8'h3F, "R1 data before address");
    // R3: select, data type
    sendByte(1'b0, 8'h14, "R3 address match");
    // R2 R4 R8: asymmetric values catch bit order, sticky selection
    sendByte(1'b1, 8'b00_101001, "R2 R4 volume");
    sendByte(1'b1, 8'b01_010110, "R4 R8 bass");
    sendByte(1'b1, 8'b10_110011, "R4 R8 treble");
    sendByte(1'b1, 8'b11_000111, "R4 R8 misc");
    sendByte(1'b1, 8'b00_000000, "R4 volume zero");
    sendByte(1'b1, 8'b00_111111, "R4 volume full");
    // R5: status group
    sendByte(1'b0, 8'h16, "R5 address status");
    sendByte(1'b1, 8'b00_100001, "R5 status0");
    sendByte(1'b1, 8'b01_011010, "R5 status1");
    sendByte(1'b1, 8'b10_001100, "R5 status2");
    sendByte(1'b1, 8'b11_110101, "R5 R8 status3");
    // R6: unused types
    sendByte(1'b0, 8'h15, "R6 address type01");
    sendByte(1'b1, 8'b00_010101, "R6 type01 ignored");
    sendByte(1'b0, 8'h17, "R6 address type11");
    sendByte(1'b1, 8'b10_000001, "R6 type11 ignored");
    // R7: mismatched addresses
    sendByte(1'b0, 8'h14, "R7 reselect");
    sendByte(1'b0, 8'h94, "R7 wrong address high bit");
    sendByte(1'b1, 8'b00_001111, "R7 ignored after mismatch");
    sendByte(1'b0, 8'h10, "R7 wrong address low bit");
    sendByte(1'b1, 8'b01_111000, "R7 ignored after near miss");
    // R9: partial byte dropped on mode change
    sendByte(1'b0, 8'h14, "R9 reselect");
    serMode = 1'b1;
    waitClk(6);
    sendBits(8'b1010_1111, 4);
    waitClk(6);
    pushExp("R9 no write after partial byte");
    serMode = 1'b0;
    waitClk(8);
    serMode = 1'b1;
    waitClk(8);
    sendByte(1'b1, 8'b10_011001, "R9 R10 byte after discarded bits");
    waitClk(4);
    while (q.size() > 0) waitClk(1);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule